// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Port Controller

This block controls a small general-purpose I/O port. A synchronous register bus writes six byte-wide registers: a data register, a direction register, two drive/pull control registers and two alternate-function mode registers. From these registers the block produces pad-control signals for each pin: output enable, drive-high enable, drive-low enable, pull-up enable and pull-down enable.

The direction bit sets each pin to input or output. In output mode, a two-bit control code per pin selects no drive, high-side-only (P-channel open-drain) drive, low-side-only (N-channel open-drain) drive or full push-pull drive. In input mode, the same code selects a floating input, a pull-down or a pull-up. A two-bit mode code per pin can replace the port data bit with one of three peripheral output values, and the selected drive style still applies to that value.

Pad input levels pass through a two-flop synchronizer. The synchronized levels go to peripherals and are also returned by reads of the data register for pins in input mode. Pins used as peripheral inputs are set to input mode. Pins used for analog signals are left in the non-driving output state, which is also the state after reset.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset all registers read zero, every pin is a non-driving output, and all five pad-control outputs are low.
- R2: Offset 1 is the direction register. Bit i = 1 puts pin i in input mode and bit i = 0 puts it in output mode. A written value reads back unchanged.
- R3: In output mode the code {ctl1[i],ctl0[i]} (ctl0 at offset 2, ctl1 at offset 3) selects the drive style. 00 drives nothing. 01 asserts drive-high only when the pin value is 1. 10 asserts drive-low only when the pin value is 0. 11 asserts drive-high for value 1 and drive-low for value 0.
- R4: A pin's output enable is high exactly when its drive-high or drive-low enable is high.
- R5: In input mode no driver is enabled. Code 01 enables the pull-down, code 10 enables the pull-up, and codes 00 and 11 enable neither. No pull is ever enabled in output mode.
- R6: The mode code {mode1[i],mode0[i]} (mode0 at offset 4, mode1 at offset 5) selects the pin value. 00 selects the data register bit (offset 0), 01 selects alternate output 1, 10 selects alternate output 2 and 11 selects alternate output 3.
- R7: A read of offset 0 returns the synchronized pad level for input-mode pins and the data register bit for output-mode pins. A pad change becomes visible to a read issued on the third clock edge after the change and no earlier.
- R8: The synchronized pin level presented to peripherals equals the pad input as it was two clock edges earlier.
- R9: Offsets 6 and 7 read as zero, and writes to them change no register.
- R10: Read data is registered. It appears after the clock edge that samples the read request and holds until the next read, so writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| altFn1 | input | 8 | Alternate peripheral output 1, one bit per pin |
| altFn2 | input | 8 | Alternate peripheral output 2, one bit per pin |
| altFn3 | input | 8 | Alternate peripheral output 3, one bit per pin |
| padIn | input | 8 | Raw pad input levels |
| pinSync | output | 8 | Synchronized pad levels for peripherals |
| padOe | output | 8 | Pad output enable |
| padDrvHi | output | 8 | Pad high-side driver enable |
| padDrvLo | output | 8 | Pad low-side driver enable |
| padPullUp | output | 8 | Pad pull-up enable |
| padPullDn | output | 8 | Pad pull-down enable |

## Verification
A data-register read and a pad input transition can occur in the same cycle. The question is which level the read returns. The bench changes the pad levels of input-mode pins on the same falling edge that it issues a read. It then issues two more reads back to back. It expects the first two reads to return the old level and the third to return the new level. Across the same edges it checks that the synchronized peripheral output changes after exactly two edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTL0  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CTL1  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MODE0 = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_MODE1 = 3'd5;

  // strobes from bus decode to the register datapath
  typedef struct packed {
    logic              wrData;
    logic              wrDir;
    logic              wrCtl0;
    logic              wrCtl1;
    logic              wrMode0;
    logic              wrMode1;
    logic              rdEn;
    logic [ADDR_W-1:0] rdSel;
  } strobe_t;

  typedef struct packed {
    logic oe;
    logic hi;
    logic lo;
    logic pu;
    logic pd;
  } padCtl_t;

  // per-pin pad decode: isInput, style code {ctl1,ctl0}, pin value
  function automatic padCtl_t decodePad(input logic isInput,
                                        input logic [1:0] style,
                                        input logic value);
    padCtl_t p;
    p = '0;
    if (isInput) begin
      unique case (style)
        2'b01:   p.pd = 1'b1;
        2'b10:   p.pu = 1'b1;
        default: ;
      endcase
    end else begin
      unique case (style)
        2'b01:   p.hi = value;
        2'b10:   p.lo = ~value;
        2'b11: begin
          p.hi = value;
          p.lo = ~value;
        end
        default: ;
      endcase
    end
    p.oe = p.hi | p.lo;
    return p;
  endfunction

endpackage

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  logic doWrite;
  assign doWrite = busSel & busWr;

  always_comb begin
    stb       = '0;
    stb.rdEn  = busSel & ~busWr;
    stb.rdSel = busAddr;
    if (doWrite) begin
      unique case (busAddr)
        OFS_DATA:  stb.wrData  = 1'b1;
        OFS_DIR:   stb.wrDir   = 1'b1;
        OFS_CTL0:  stb.wrCtl0  = 1'b1;
        OFS_CTL1:  stb.wrCtl1  = 1'b1;
        OFS_MODE0: stb.wrMode0 = 1'b1;
        OFS_MODE1: stb.wrMode1 = 1'b1;
        default:   ;
      endcase
    end
  end

  // R9: at most one register is written per access
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrData, stb.wrDir, stb.wrCtl0, stb.wrCtl1, stb.wrMode0, stb.wrMode1}));

  // R9: unused offsets raise no write strobe
  a_r9_unused_offset: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr > OFS_MODE1) |->
      !(stb.wrData | stb.wrDir | stb.wrCtl0 | stb.wrCtl1 | stb.wrMode0 | stb.wrMode1));

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] altFn1,
  input  logic [NUM_PINS-1:0] altFn2,
  input  logic [NUM_PINS-1:0] altFn3,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] pinSync,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padDrvHi,
  output logic [NUM_PINS-1:0] padDrvLo,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padPullDn
);

  logic [NUM_PINS-1:0] dataReg, dirReg, ctl0Reg, ctl1Reg, mode0Reg, mode1Reg;
  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];
  logic [NUM_PINS-1:0] rdNext;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      dirReg   <= '0;
      ctl0Reg  <= '0;
      ctl1Reg  <= '0;
      mode0Reg <= '0;
      mode1Reg <= '0;
    end else begin
      if (stb.wrData)  dataReg  <= busWdata;
      if (stb.wrDir)   dirReg   <= busWdata;
      if (stb.wrCtl0)  ctl0Reg  <= busWdata;
      if (stb.wrCtl1)  ctl1Reg  <= busWdata;
      if (stb.wrMode0) mode0Reg <= busWdata;
      if (stb.wrMode1) mode1Reg <= busWdata;
    end
  end

  // input synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end
  assign pinSync = syncStage[SYNC_STAGES-1];

  // per-pin value mux and pad decode
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] modeSel;
    logic       pinVal;
    padCtl_t    pad;

    assign modeSel = {mode1Reg[i], mode0Reg[i]};

    always_comb begin
      unique case (modeSel)
        2'b00: pinVal = dataReg[i];
        2'b01: pinVal = altFn1[i];
        2'b10: pinVal = altFn2[i];
        default: pinVal = altFn3[i];
      endcase
    end

    assign pad = decodePad(dirReg[i], {ctl1Reg[i], ctl0Reg[i]}, pinVal);

    assign padOe[i]     = pad.oe;
    assign padDrvHi[i]  = pad.hi;
    assign padDrvLo[i]  = pad.lo;
    assign padPullUp[i] = pad.pu;
    assign padPullDn[i] = pad.pd;

    // R6: push-pull, port mode -> pad follows the data register
    a_r6_port_value: assert property (@(posedge clk) disable iff (!rstN)
      (!dirReg[i] && ctl0Reg[i] && ctl1Reg[i] && !mode0Reg[i] && !mode1Reg[i])
        |-> (padDrvHi[i] == dataReg[i]) && (padDrvLo[i] == !dataReg[i]));
  end

  // read mux and registered read data
  always_comb begin
    unique case (stb.rdSel)
      OFS_DATA:  rdNext = (dirReg & pinSync) | (~dirReg & dataReg);
      OFS_DIR:   rdNext = dirReg;
      OFS_CTL0:  rdNext = ctl0Reg;
      OFS_CTL1:  rdNext = ctl1Reg;
      OFS_MODE0: rdNext = mode0Reg;
      OFS_MODE1: rdNext = mode1Reg;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdNext;
  end

  // R5: input pins never drive, output pins never pull
  a_r5_no_drive_in_input: assert property (@(posedge clk) disable iff (!rstN)
    ((padDrvHi | padDrvLo) & dirReg) == '0);
  a_r5_no_pull_in_output: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullUp | padPullDn) & ~dirReg) == '0);

  // R2: a direction write lands on the next edge
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDir |=> dirReg == $past(busWdata));

  // R10: read data holds without a read request
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(busRdata));

  // R8: synchronized level lags the pad by two edges once primed
  logic [1:0] primeCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                primeCnt <= '0;
    else if (primeCnt != 2'd3) primeCnt <= primeCnt + 2'd1;
  end
  if (SYNC_STAGES == 2) begin : g_syncChk
    a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
      (primeCnt == 2'd3) |-> pinSync == $past(padIn, 2));
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] altFn1,
  input  logic [NUM_PINS-1:0] altFn2,
  input  logic [NUM_PINS-1:0] altFn3,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] pinSync,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padDrvHi,
  output logic [NUM_PINS-1:0] padDrvLo,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padPullDn
);

  strobe_t stb;

  gpio_port_ctl i_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  gpio_port_dp #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .altFn1    (altFn1),
    .altFn2    (altFn2),
    .altFn3    (altFn3),
    .padIn     (padIn),
    .pinSync   (pinSync),
    .padOe     (padOe),
    .padDrvHi  (padDrvHi),
    .padDrvLo  (padDrvLo),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn)
  );

endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] altFn1 = '0, altFn2 = '0, altFn3 = '0;
  logic [7:0] padIn = '0;
  logic [7:0] pinSync, padOe, padDrvHi, padDrvLo, padPullUp, padPullDn;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .altFn1(altFn1), .altFn2(altFn2),
    .altFn3(altFn3), .padIn(padIn), .pinSync(pinSync), .padOe(padOe),
    .padDrvHi(padDrvHi), .padDrvLo(padDrvLo), .padPullUp(padPullUp),
    .padPullDn(padPullDn)
  );

  // stimulus: dir, ctl0, ctl1, mode0, mode1, data, alt1, alt2, alt3
  localparam logic [71:0] VECS [11] = '{
    72'h00_FF_FF_00_00_A5_00_00_00,
    72'h00_FF_00_00_00_3C_00_00_00,
    72'h00_00_FF_00_00_3C_00_00_00,
    72'h00_00_00_00_00_FF_FF_FF_FF,
    72'hFF_FF_00_00_00_00_00_00_00,
    72'hFF_00_FF_00_00_FF_00_00_00,
    72'hFF_FF_FF_00_00_FF_FF_FF_FF,
    72'h00_FF_FF_FF_00_00_5A_C3_0F,
    72'h00_FF_FF_00_FF_00_5A_C3_0F,
    72'h00_FF_FF_FF_FF_00_5A_C3_0F,
    72'h0F_55_33_0F_F0_96_69_A5_3C
  };

  // expected {oe, hi, lo, pu, pd} from the requirement text
  function automatic logic [39:0] model(input logic [71:0] v);
    logic [7:0] dir, c0, c1, m0, m1, dat, a1, a2, a3;
    logic [7:0] oe, hi, lo, pu, pd;
    {dir, c0, c1, m0, m1, dat, a1, a2, a3} = v;
    oe = '0; hi = '0; lo = '0; pu = '0; pd = '0;
    for (int i = 0; i < 8; i++) begin
      logic val;
      case ({m1[i], m0[i]})
        2'b00: val = dat[i];
        2'b01: val = a1[i];
        2'b10: val = a2[i];
        default: val = a3[i];
      endcase
      if (dir[i]) begin
        pd[i] = ({c1[i], c0[i]} == 2'b01);
        pu[i] = ({c1[i], c0[i]} == 2'b10);
      end else begin
        hi[i] = c0[i] & val;
        lo[i] = c1[i] & ~val;
      end
      oe[i] = hi[i] | lo[i];
    end
    return {oe, hi, lo, pu, pd};
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks are entered at a falling edge and return at a falling edge
  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] r1, r2, r3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 pads", {padOe, padDrvHi, padDrvLo, padPullUp, padPullDn}, '0);
    for (int a = 0; a < 6; a++) begin
      busRead(3'(a), rd);
      check("R1 regs", {32'h0, rd}, 40'h0);
    end

    // vector table: R3 R4 R5 R6 and the output-pin part of R7
    padIn = 8'h5A;
    foreach (VECS[k]) begin
      logic [7:0] dir, c0, c1, m0, m1, dat;
      {dir, c0, c1, m0, m1, dat, altFn1, altFn2, altFn3} = VECS[k];
      busWrite(3'd1, dir);
      busWrite(3'd2, c0);
      busWrite(3'd3, c1);
      busWrite(3'd4, m0);
      busWrite(3'd5, m1);
      busWrite(3'd0, dat);
      check("R3/R4/R5/R6 pads", {padOe, padDrvHi, padDrvLo, padPullUp, padPullDn},
            model(VECS[k]));
      busRead(3'd0, rd);
      check("R7 data read", {32'h0, rd}, {32'h0, (dir & 8'h5A) | (~dir & dat)});
    end

    // R2: direction readback
    busWrite(3'd1, 8'hC3);
    busRead(3'd1, rd);
    check("R2 dir readback", {32'h0, rd}, {32'h0, 8'hC3});

    // R9: unused offsets
    busWrite(3'd4, 8'h21);
    busWrite(3'd6, 8'hFF);
    busWrite(3'd7, 8'hEE);
    busRead(3'd6, rd);
    check("R9 offset 6 reads zero", {32'h0, rd}, 40'h0);
    busRead(3'd7, rd);
    check("R9 offset 7 reads zero", {32'h0, rd}, 40'h0);
    busRead(3'd4, rd);
    check("R9 mode0 untouched", {32'h0, rd}, {32'h0, 8'h21});
    busRead(3'd1, rd);
    check("R9 dir untouched", {32'h0, rd}, {32'h0, 8'hC3});

    // R10: read data holds across a write
    busWrite(3'd1, 8'h3C);
    @(negedge clk);
    check("R10 rdata hold", {32'h0, busRdata}, {32'h0, 8'hC3});

    // R7/R8: pad change coincides with a data read
    busWrite(3'd1, 8'hFF);
    busWrite(3'd4, 8'h00);
    padIn = 8'h5A;
    repeat (3) @(negedge clk);
    padIn = 8'hA5;
    busRead(3'd0, r1);
    check("R8 sync after one edge", {32'h0, pinSync}, {32'h0, 8'h5A});
    busRead(3'd0, r2);
    check("R8 sync after two edges", {32'h0, pinSync}, {32'h0, 8'hA5});
    busRead(3'd0, r3);
    check("R7 read at change edge", {32'h0, r1}, {32'h0, 8'h5A});
    check("R7 read at second edge", {32'h0, r2}, {32'h0, 8'h5A});
    check("R7 read at third edge", {32'h0, r3}, {32'h0, 8'hA5});

    // R1: reset returns pads to non-driving output
    busWrite(3'd1, 8'h00);
    busWrite(3'd2, 8'hFF);
    busWrite(3'd3, 8'hFF);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 pads after reset", {padOe, padDrvHi, padDrvLo, padPullUp, padPullDn}, '0);
    busRead(3'd2, rd);
    check("R1 ctl0 after reset", {32'h0, rd}, 40'h0);

    summary();
  end

endmodule